// File: doc/BRIEF.md
# Clock Synthesizer Control Register Bank

This block is the digital control core of a multi-output clock synthesizer. A byte-wide write/read port, fed by a serial slave front end that sits outside this block, reaches three configuration bytes. The block captures the frequency-select strap pins and a supply-voltage strap while reset is held. It picks the effective 3-bit frequency code either from those captured straps or from a register field, and turns that code into CPU, PCI and AGP frequency words in units of 10 kHz.

It also drives the spread-spectrum controls, a global tristate request, and one output-enable per clock: three CPU clocks, one SDRAM feedback clock, five PCI clocks and one free-running PCI clock. The inverted strap values read back through read-only bits inside the enable bytes. When the effective code changes, a one-cycle update pulse tells the downstream PLL logic to begin a smooth transition.

Top module: `clkSynthCtrlBank`

## Requirements
- R1: After reset, byte 0 reads 0x00; every clock enable is 1; byte 1 reads {1, ~fs[2], ~fs[1], 1, 0, 1, 1, 1} and byte 2 reads {volt, 1, ~fs[0], 1, 1, 1, 1, 1}, where fs and volt are the captured straps.
- R2: The straps are sampled on every clock edge while rstN is low and hold their last sampled value while rstN is high; later strap changes have no effect on readback or on the frequency code.
- R3: Byte 0 bit 1 drives spreadEn, bit 2 drives spreadDown (1 = down spread, 0 = center), bit 7 drives spreadWide (1 = wider amplitude), and bit 0 drives tristate.
- R4: With byte 0 bit 3 at 0 the effective code is the captured strap code; with bit 3 at 1 it is byte 0 bits 6:4. freqCode shows the effective code one clock edge after the register write.
- R5: The frequency words (CPU/PCI/AGP, 10 kHz units) per code are: 7: 10000/3330/6660, 6: 9525/3175/6350, 5: 8330/3330/6660, 4: 7500/3000/6000, 3: 7500/3750/7500, 2: 6850/3425/6850, 1: 6680/3340/6680, 0: 6000/3000/6000.
- R6: Byte 1 bits 2:0 enable CPU clocks 2..0 and bit 4 the SDRAM clock; byte 2 bits 4:0 enable PCI clocks 4..0 and bit 6 the free-running PCI clock. A 0 drives the matching output-enable low.
- R7: While tristate is 1, every output-enable is 0 regardless of the enable bits.
- R8: Writes to read-only and reserved bits are ignored: byte 1 bit 7 always reads 1, bit 3 reads 0, bits 6:5 read ~fs[2:1]; byte 2 bit 5 reads ~fs[0], bit 7 reads volt; address 3 reads 0x00.
- R9: freqUpdate is 1 for exactly the cycle in which freqCode first shows a new value, and 0 otherwise, including after reset.
- R10: A write with wrEn high updates the addressed byte on that clock edge; rdData reflects the addressed byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; straps are sampled while low |
| strapFs | input | 3 | Frequency-select strap pins |
| strapVolt | input | 1 | CPU supply-voltage strap |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Byte address (0..2 used) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| freqCode | output | 3 | Effective frequency code |
| cpuFreq | output | 16 | CPU frequency, 10 kHz units |
| pciFreq | output | 16 | PCI frequency, 10 kHz units |
| agpFreq | output | 16 | AGP frequency, 10 kHz units |
| freqUpdate | output | 1 | One-cycle pulse on a frequency code change |
| spreadEn | output | 1 | Spread-spectrum enable |
| spreadDown | output | 1 | Spread type: 1 down, 0 center |
| spreadWide | output | 1 | Spread amplitude: 1 wide, 0 narrow |
| tristate | output | 1 | Global high-impedance request |
| cpuOe | output | 3 | CPU clock output-enables |
| sdramOe | output | 1 | SDRAM feedback clock output-enable |
| pciOe | output | 5 | PCI clock output-enables |
| pciFreeOe | output | 1 | Free-running PCI clock output-enable |

## Verification
A single write to byte 0 can at once flip the frequency source and load a new code, and can set tristate in the same cycle, so the update pulse, the new frequency words and the forced-off enables all follow from one edge. The bench provokes this with random byte 0 values interleaved with random enable-byte writes and judges, one edge after each write, the code, the pulse (expected only if the model's effective code moved) and every enable against a reference model. Strap changes after reset are mixed in to show that the source select, not the pins, governs the code.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  localparam int DATA_W = 8;
  localparam int FREQ_W = 16;
  localparam int CODE_W = 3;

  // Byte 1: bit7 reserved (reads 1), bits 6:5 strap view, bit4 sdram, bit3 reserved, bits 2:0 cpu
  localparam logic [DATA_W-1:0] B1_RST    = 8'h97;
  localparam logic [DATA_W-1:0] B1_WMASK  = 8'h17;
  localparam logic [DATA_W-1:0] B1_ROMASK = 8'h60;
  // Byte 2: bit7 voltage strap, bit6 free pci, bit5 strap view, bits 4:0 pci
  localparam logic [DATA_W-1:0] B2_RST    = 8'h5F;
  localparam logic [DATA_W-1:0] B2_WMASK  = 8'h5F;
  localparam logic [DATA_W-1:0] B2_ROMASK = 8'hA0;

  typedef struct packed {
    logic       wr0;
    logic       wr1;
    logic       wr2;
    logic [1:0] rdSel;
  } regStrobe_t;

  typedef struct packed {
    logic [FREQ_W-1:0] cpu;
    logic [FREQ_W-1:0] pci;
    logic [FREQ_W-1:0] agp;
  } freqSet_t;

  function automatic freqSet_t decodeFreq(input logic [CODE_W-1:0] code);
    freqSet_t f;
    case (code)
      3'd7:    f = '{16'd10000, 16'd3330, 16'd6660};
      3'd6:    f = '{16'd9525,  16'd3175, 16'd6350};
      3'd5:    f = '{16'd8330,  16'd3330, 16'd6660};
      3'd4:    f = '{16'd7500,  16'd3000, 16'd6000};
      3'd3:    f = '{16'd7500,  16'd3750, 16'd7500};
      3'd2:    f = '{16'd6850,  16'd3425, 16'd6850};
      3'd1:    f = '{16'd6680,  16'd3340, 16'd6680};
      default: f = '{16'd6000,  16'd3000, 16'd6000};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/clkSynthAccess.sv
module clkSynthAccess
  import clk_synth_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  output regStrobe_t strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = addr;
    if (wrEn) begin
      case (addr)
        2'd0:    strb.wr0 = 1'b1;
        2'd1:    strb.wr1 = 1'b1;
        2'd2:    strb.wr2 = 1'b1;
        default: ;
      endcase
    end
  end

  // R10: a write to a used address raises exactly one byte strobe
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != 2'd3) |-> $countones({strb.wr0, strb.wr1, strb.wr2}) == 1);

  // R10: no strobe without a write
  assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wr0 || strb.wr1 || strb.wr2));

endmodule

// File: rtl/clkSynthDatapath.sv
module clkSynthDatapath
  import clk_synth_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] strapFs,
  input  logic              strapVolt,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] freqCode,
  output logic [FREQ_W-1:0] cpuFreq,
  output logic [FREQ_W-1:0] pciFreq,
  output logic [FREQ_W-1:0] agpFreq,
  output logic              freqUpdate,
  output logic              spreadEn,
  output logic              spreadDown,
  output logic              spreadWide,
  output logic              tristate,
  output logic [2:0]        cpuOe,
  output logic              sdramOe,
  output logic [4:0]        pciOe,
  output logic              pciFreeOe
);

  logic [DATA_W-1:0] cfg0, cfg1, cfg2;
  logic [CODE_W-1:0] fsLat, codeQ, effCode;
  logic              voltLat, updQ, oeGate;
  logic [DATA_W-1:0] view1, view2;
  freqSet_t          freqNow;

  assign effCode = cfg0[3] ? cfg0[6:4] : fsLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg0    <= '0;
      cfg1    <= B1_RST;
      cfg2    <= B2_RST;
      fsLat   <= strapFs;
      voltLat <= strapVolt;
      codeQ   <= strapFs;
      updQ    <= 1'b0;
    end else begin
      if (strb.wr0) cfg0 <= wrData;
      if (strb.wr1) cfg1 <= (cfg1 & ~B1_WMASK) | (wrData & B1_WMASK);
      if (strb.wr2) cfg2 <= (cfg2 & ~B2_WMASK) | (wrData & B2_WMASK);
      codeQ <= effCode;
      updQ  <= (effCode != codeQ);
    end
  end

  assign view1 = (cfg1 & ~B1_ROMASK) | ({1'b0, ~fsLat[2], ~fsLat[1], 5'b0} & B1_ROMASK);
  assign view2 = (cfg2 & ~B2_ROMASK) | ({voltLat, 1'b0, ~fsLat[0], 5'b0} & B2_ROMASK);

  always_comb begin
    case (strb.rdSel)
      2'd0:    rdData = cfg0;
      2'd1:    rdData = view1;
      2'd2:    rdData = view2;
      default: rdData = '0;
    endcase
  end

  assign freqNow    = decodeFreq(codeQ);
  assign freqCode   = codeQ;
  assign cpuFreq    = freqNow.cpu;
  assign pciFreq    = freqNow.pci;
  assign agpFreq    = freqNow.agp;
  assign freqUpdate = updQ;

  assign spreadEn   = cfg0[1];
  assign spreadDown = cfg0[2];
  assign spreadWide = cfg0[7];
  assign tristate   = cfg0[0];
  assign oeGate     = ~cfg0[0];

  assign cpuOe     = cfg1[2:0] & {3{oeGate}};
  assign sdramOe   = cfg1[4] & oeGate;
  assign pciOe     = cfg2[4:0] & {5{oeGate}};
  assign pciFreeOe = cfg2[6] & oeGate;

  // R7: global tristate silences every enable
  assert_tristate_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    tristate |-> (cpuOe == 3'b0 && !sdramOe && pciOe == 5'b0 && !pciFreeOe));

  // R2: captured straps never move outside reset
  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($stable(fsLat) && $stable(voltLat)));

  // R9: a pulse only accompanies a changed code
  assert_update_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    freqUpdate |-> (freqCode != $past(freqCode)));

  // R6: enable byte 1 only moves on its own write
  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr1 |=> $stable(cfg1));

endmodule

// File: rtl/clkSynthCtrlBank.sv
module clkSynthCtrlBank
  import clk_synth_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] strapFs,
  input  logic              strapVolt,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] freqCode,
  output logic [FREQ_W-1:0] cpuFreq,
  output logic [FREQ_W-1:0] pciFreq,
  output logic [FREQ_W-1:0] agpFreq,
  output logic              freqUpdate,
  output logic              spreadEn,
  output logic              spreadDown,
  output logic              spreadWide,
  output logic              tristate,
  output logic [2:0]        cpuOe,
  output logic              sdramOe,
  output logic [4:0]        pciOe,
  output logic              pciFreeOe
);

  regStrobe_t strb;

  clkSynthAccess uAccess (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  clkSynthDatapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .strapFs    (strapFs),
    .strapVolt  (strapVolt),
    .rdData     (rdData),
    .freqCode   (freqCode),
    .cpuFreq    (cpuFreq),
    .pciFreq    (pciFreq),
    .agpFreq    (agpFreq),
    .freqUpdate (freqUpdate),
    .spreadEn   (spreadEn),
    .spreadDown (spreadDown),
    .spreadWide (spreadWide),
    .tristate   (tristate),
    .cpuOe      (cpuOe),
    .sdramOe    (sdramOe),
    .pciOe      (pciOe),
    .pciFreeOe  (pciFreeOe)
  );

endmodule

// File: tb/tb_clkSynthCtrlBank.sv
module tb_clkSynthCtrlBank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  strapFs;
  logic        strapVolt;
  logic        wrEn;
  logic [1:0]  addr;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic [2:0]  freqCode;
  logic [15:0] cpuFreq, pciFreq, agpFreq;
  logic        freqUpdate, spreadEn, spreadDown, spreadWide, tristate;
  logic [2:0]  cpuOe;
  logic        sdramOe;
  logic [4:0]  pciOe;
  logic        pciFreeOe;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [7:0] m0;
  logic [7:0] m1;
  logic [7:0] m2;
  logic [2:0] mFs;
  logic       mVolt;
  logic [2:0] mCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkSynthCtrlBank dut (.*);

  function automatic logic [2:0] expEff();
    return m0[3] ? m0[6:4] : mFs;
  endfunction

  function automatic logic [47:0] expFreq(input logic [2:0] c);
    case (c)
      3'd7: return {16'd10000, 16'd3330, 16'd6660};
      3'd6: return {16'd9525, 16'd3175, 16'd6350};
      3'd5: return {16'd8330, 16'd3330, 16'd6660};
      3'd4: return {16'd7500, 16'd3000, 16'd6000};
      3'd3: return {16'd7500, 16'd3750, 16'd7500};
      3'd2: return {16'd6850, 16'd3425, 16'd6850};
      3'd1: return {16'd6680, 16'd3340, 16'd6680};
      default: return {16'd6000, 16'd3000, 16'd6000};
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return m0;
      2'd1: return {1'b1, ~mFs[2], ~mFs[1], m1[4], 1'b0, m1[2:0]};
      2'd2: return {mVolt, m2[6], ~mFs[0], m2[4:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      2'd0: m0 = d;
      2'd1: m1 = d & 8'h17;
      2'd2: m2 = d & 8'h5F;
      default: ;
    endcase
  endtask

  task automatic checkReads();
    for (int a = 0; a < 4; a++) begin
      addr = a[1:0];
      #1;
      check(a == 3 ? "R8 unused address" : "R8/R10 readback", {40'b0, rdData}, {40'b0, expRead(a[1:0])});
    end
  endtask

  task automatic checkOutputs();
    logic g;
    g = ~m0[0];
    check("R3 spread/tristate", {44'b0, spreadEn, spreadDown, spreadWide, tristate},
          {44'b0, m0[1], m0[2], m0[7], m0[0]});
    check("R6/R7 enables", {38'b0, cpuOe, sdramOe, pciOe, pciFreeOe},
          {38'b0, m1[2:0] & {3{g}}, m1[4] & g, m2[4:0] & {5{g}}, m2[6] & g});
  endtask

  // after a write: one more edge, then code, pulse and words
  task automatic checkCode();
    logic [2:0] e;
    e = expEff();
    @(posedge clk);
    @(negedge clk);
    check("R4 freqCode", {45'b0, freqCode}, {45'b0, e});
    check("R9 update pulse", {47'b0, freqUpdate}, {47'b0, e != mCode});
    check("R5 frequency words", {cpuFreq, pciFreq, agpFreq}, expFreq(e));
    mCode = e;
  endtask

  task automatic doReset(input logic [2:0] fs, input logic v);
    rstN = 1'b0; strapFs = fs; strapVolt = v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    m0 = 8'h00; m1 = 8'h17; m2 = 8'h5F; mFs = fs; mVolt = v; mCode = fs;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    wrEn = 1'b0; addr = 2'd0; wrData = 8'h00;
    doReset(3'b101, 1'b1);

    // R1: reset state
    @(negedge clk);
    checkReads();
    checkOutputs();
    check("R1 code from straps", {45'b0, freqCode}, {45'b0, 3'b101});
    check("R9 no pulse after reset", {47'b0, freqUpdate}, 48'b0);

    // R2: strap changes after reset are ignored
    strapFs = 3'b010; strapVolt = 1'b0;
    repeat (3) @(negedge clk);
    checkReads();
    check("R2 code holds", {45'b0, freqCode}, {45'b0, 3'b101});

    // R4: register source with code 6 in the same write
    writeReg(2'd0, 8'h68);
    checkCode();
    @(negedge clk);
    check("R9 pulse lasts one cycle", {47'b0, freqUpdate}, 48'b0);
    // back to strap source
    writeReg(2'd0, 8'h60);
    checkCode();

    // R8: read-only and reserved bits ignore writes
    writeReg(2'd1, 8'hFF);
    checkReads();
    writeReg(2'd1, 8'h00);
    checkReads();
    checkOutputs();
    writeReg(2'd2, 8'h00);
    checkReads();
    writeReg(2'd2, 8'hFF);
    checkReads();

    // R7 with R4 in the same write: tristate and new code together
    writeReg(2'd0, 8'hF9);
    checkOutputs();
    checkCode();

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (i % 7 == 3) strapFs = 3'($urandom);
      writeReg(a, d);
      checkOutputs();
      checkCode();
      checkReads();
    end

    // second reset with other straps
    doReset(3'b011, 1'b0);
    @(negedge clk);
    checkReads();
    check("R1 code after second reset", {45'b0, freqCode}, {45'b0, 3'b011});
    check("R5 words for code 3", {cpuFreq, pciFreq, agpFreq}, expFreq(3'b011));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule